// File: doc/BRIEF.md
# I2C Addressed Slave Memory

This block is a two-wire serial bus slave that holds a small byte-wide memory. It runs entirely on the system clock and oversamples the bus clock and data lines. It finds bus start, repeated start and stop conditions, takes in an address byte, and acknowledges when the address belongs to it. It then either stores bytes the master sends or returns bytes the master asks for. It never drives the data line high. It only asserts an output enable that pulls the wired-AND line low.

The 7-bit address has a fixed 4-bit prefix, which is a parameter, followed by a 3-bit field. The `mem_mode` input sets the role of that field. When it is low, the field must equal the `strap_bits` pins. When it is high, any value of the field is accepted and is used as the upper three bits of the memory address, which selects a page.

In a write frame, the first data byte loads the internal pointer. Each later byte goes to the current page and pointer position. The pointer advances after every byte written or read, and it wraps inside the page.

Top module: `i2c_mem_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) restarts address reception from any state, whether or not a stop came before it. Such a start with no stop before it is a repeated start.
- R2: Address byte bits are numbered 7 down to 0 and sent MSB first. The byte matches when bits [7:4] equal PREFIX and, with mem_mode = 0, bits [3:1] equal strap_bits; with mem_mode = 1, bits [3:1] may be any value. Bit 0 selects the direction: 0 means the master writes and 1 means the master reads. A match is acknowledged by holding SDA low through the ninth SCL pulse.
- R3: After a non-matching address the slave gives no acknowledge and leaves SDA released for the rest of the frame, data bytes included, until the next start condition.
- R4: In a write frame, the first data byte is acknowledged and its low PTR_W bits load the pointer. The byte itself is not stored. The pointer keeps its value across a stop.
- R5: Every later byte of a write frame is acknowledged and stored at {page, pointer}, after which the pointer advances by one. A frame may carry any number of bytes.
- R6: In a read frame, the slave sends the byte at {page, pointer} MSB first and then advances the pointer. While the master acknowledges, the slave keeps sending the following bytes.
- R7: The pointer wraps from 2^PTR_W-1 to 0 and stays within the same page, for both reads and writes.
- R8: With mem_mode = 1, address bits [3:1] of the current frame select the page, which is the top three memory address bits. With mem_mode = 0, the page is 0.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and sends nothing more until a stop or a start.
- R10: A stop condition (SDA rising while SCL is high) returns the slave to idle with SDA released.
- R11: The SDA output enable changes only while the synchronized SCL is low.
- R12: After reset, SDA is released, the pointer is 0 and every memory byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND result) |
| mem_mode | input | 1 | 0: address bits [3:1] are compared with strap_bits; 1: they select the memory page |
| strap_bits | input | 3 | Board-set address field used when mem_mode = 0 |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The address match is swept over all 128 seven-bit addresses in strap mode, which separates the prefix compare from the strap compare. Each mismatching address is followed by a data byte so that a slave that wrongly stays active would acknowledge it. In memory mode, the same pointer value is written in each of the eight pages with values unique to each page. Reading them back in reverse order, including one read whose page differs from the page of the frame that set the pointer, shows whether the page comes from the current address byte. In strap mode, a run of seventeen writes and a four-byte read that starts near the end of the page show wrap-around apart from plain increment. A read ending with a NACK, followed by one more clock pulse, shows whether SDA is released.

// File: rtl/i2c_mem_pkg.sv
`timescale 1ns/1ps
package i2c_mem_pkg;

  localparam int PAGE_W   = 3;
  localparam int PREFIX_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK,
    ST_WAIT
  } slv_state_e;

  // Address compare: prefix always, low field only when strapped.
  function automatic logic addr_match(input logic [6:0] a,
                                      input logic [PREFIX_W-1:0] prefix,
                                      input logic mem_mode,
                                      input logic [PAGE_W-1:0] strap);
    return (a[6:3] == prefix) && (mem_mode || (a[2:0] == strap));
  endfunction

  // Page used for the memory: taken from the address only in memory mode.
  function automatic logic [PAGE_W-1:0] page_of(input logic [6:0] a,
                                                input logic mem_mode);
    return mem_mode ? a[2:0] : '0;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic evt_rise,
  output logic evt_fall,
  output logic evt_start,
  output logic evt_stop
);

  logic [STAGES-1:0] scl_p;
  logic [STAGES-1:0] sda_p;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p[0] <= scl_i;
      sda_p[0] <= sda_i;
      for (int k = 1; k < STAGES; k++) begin
        scl_p[k] <= scl_p[k-1];
        sda_p[k] <= sda_p[k-1];
      end
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign evt_rise  = scl_s & ~scl_d;
  assign evt_fall  = ~scl_s & scl_d;
  assign evt_start = scl_s & scl_d & sda_d & ~sda_s;
  assign evt_stop  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_byte_mem.sv
`timescale 1ns/1ps
module i2c_byte_mem #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/i2c_slave_fsm.sv
`timescale 1ns/1ps
module i2c_slave_fsm
  import i2c_mem_pkg::*;
#(
  parameter logic [3:0] PREFIX = 4'hA,
  parameter int         PTR_W  = 8,
  localparam int        MEM_AW = PTR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_start,
  input  logic              evt_stop,
  input  logic              evt_rise,
  input  logic              evt_fall,
  input  logic              sda_s,
  input  logic              mem_mode,
  input  logic [2:0]        strap_bits,
  input  logic [7:0]        rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        wr_data,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [3:0]        bit_cnt,
  output logic              byte_done,
  output logic              addr_hit,
  output logic              ptr_load,
  output logic              in_wait
);

  slv_state_e        st;
  logic [7:0]        sh;
  logic [7:0]        tx;
  logic              rw_q;
  logic              first_q;
  logic              mack_q;
  logic [PAGE_W-1:0] page_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return p + {{(PTR_W-1){1'b0}}, 1'b1};
  endfunction

  assign byte_done = evt_fall && (bit_cnt == 4'd8) && ((st == ST_ADDR) || (st == ST_WR));
  assign addr_hit  = addr_match(sh[7:1], PREFIX, mem_mode, strap_bits);
  assign ptr_load  = byte_done && (st == ST_WR) && first_q;
  assign wr_en     = byte_done && (st == ST_WR) && !first_q;
  assign wr_data   = sh;
  assign mem_addr  = {page_q, ptr_q};
  assign in_wait   = (st == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sh      <= '0;
      tx      <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      mack_q  <= 1'b0;
      page_q  <= '0;
      ptr_q   <= '0;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (evt_start) begin
      st      <= ST_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (evt_stop) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_WR: begin
          if (evt_rise && bit_cnt != 4'd8) begin
            sh      <= {sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            if (st == ST_ADDR) begin
              if (addr_hit) begin
                st     <= ST_AACK;
                sda_oe <= 1'b1;
                rw_q   <= sh[0];
                page_q <= page_of(sh[7:1], mem_mode);
              end else begin
                st <= ST_WAIT;
              end
            end else begin
              st      <= ST_WACK;
              sda_oe  <= 1'b1;
              first_q <= 1'b0;
              if (first_q) ptr_q <= sh[PTR_W-1:0];
              else         ptr_q <= ptr_next(ptr_q);
            end
          end
        end
        ST_AACK: begin
          if (evt_fall) begin
            bit_cnt <= '0;
            if (rw_q) begin
              st     <= ST_RD;
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              st      <= ST_WR;
              first_q <= 1'b1;
              sda_oe  <= 1'b0;
            end
          end
        end
        ST_WACK: begin
          if (evt_fall) begin
            st      <= ST_WR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
          end
        end
        ST_RD: begin
          if (evt_rise && bit_cnt != 4'd8) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (evt_fall && bit_cnt != 4'd0) begin
            if (bit_cnt == 4'd8) begin
              st     <= ST_RACK;
              sda_oe <= 1'b0;
              ptr_q  <= ptr_next(ptr_q);
            end else begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end
          end
        end
        ST_RACK: begin
          if (evt_rise) begin
            mack_q <= ~sda_s;
          end else if (evt_fall) begin
            if (mack_q) begin
              st      <= ST_RD;
              bit_cnt <= '0;
              tx      <= rd_data;
              sda_oe  <= ~rd_data[7];
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_mem_slave.sv
`timescale 1ns/1ps
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter logic [3:0] PREFIX      = 4'hA,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        MEM_AW      = PTR_W + PAGE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       mem_mode,
  input  logic [2:0] strap_bits,
  output logic       sda_oe
);

  logic              scl_s;
  logic              sda_s;
  logic              evt_rise;
  logic              evt_fall;
  logic              evt_start;
  logic              evt_stop;
  logic              wr_en;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0]        wr_data;
  logic [7:0]        rd_data;
  logic [PTR_W-1:0]  ptr_q;
  logic [3:0]        bit_cnt;
  logic              byte_done;
  logic              addr_hit;
  logic              ptr_load;
  logic              in_wait;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .evt_rise(evt_rise), .evt_fall(evt_fall),
    .evt_start(evt_start), .evt_stop(evt_stop)
  );

  i2c_slave_fsm #(.PREFIX(PREFIX), .PTR_W(PTR_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_stop(evt_stop),
    .evt_rise(evt_rise), .evt_fall(evt_fall), .sda_s(sda_s),
    .mem_mode(mem_mode), .strap_bits(strap_bits), .rd_data(rd_data),
    .sda_oe(sda_oe), .wr_en(wr_en), .mem_addr(mem_addr), .wr_data(wr_data),
    .ptr_q(ptr_q), .bit_cnt(bit_cnt), .byte_done(byte_done),
    .addr_hit(addr_hit), .ptr_load(ptr_load), .in_wait(in_wait)
  );

  i2c_byte_mem #(.AW(MEM_AW)) mem_i (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .addr(mem_addr),
    .wdata(wr_data), .rdata(rd_data)
  );

endmodule

// File: rtl/i2c_mem_slave_chk.sv
`timescale 1ns/1ps
module i2c_mem_slave_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_oe,
  input logic             evt_start,
  input logic             evt_stop,
  input logic [3:0]       bit_cnt,
  input logic             in_wait,
  input logic             wr_en,
  input logic             ptr_load,
  input logic [PTR_W-1:0] ptr_q
);

  logic [PTR_W-1:0] ptr_plus;
  assign ptr_plus = ptr_q + {{(PTR_W-1){1'b0}}, 1'b1};

  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  assert_start_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |=> (bit_cnt == 4'd0) && !sda_oe);

  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop |=> !sda_oe);

  assert_mismatch_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !sda_oe);

  assert_load_or_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, ptr_load}));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr_q == $past(ptr_plus));

endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .evt_start(evt_start), .evt_stop(evt_stop), .bit_cnt(bit_cnt),
  .in_wait(in_wait), .wr_en(wr_en), .ptr_load(ptr_load), .ptr_q(ptr_q)
);

// File: tb/i2c_mem_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_mem_slave_tb_top;

  localparam logic [3:0] PREFIX = 4'hA;
  localparam int PTR_W = 4;
  localparam int PSZ   = 1 << PTR_W;
  localparam int Q     = 6;
  localparam int H     = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       mem_mode = 1'b0;
  logic [2:0] strap = 3'b101;
  logic       sda_oe;
  wire        sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] bm [0:(8*PSZ)-1];

  always #2.5 clk = ~clk;

  i2c_mem_slave #(.PREFIX(PREFIX), .PTR_W(PTR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .mem_mode(mem_mode), .strap_bits(strap), .sda_oe(sda_oe)
  );

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(H);
    sda_m = 1'b0; waitc(H); scl_m = 1'b0; waitc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitc(Q); scl_m = 1'b1; waitc(H); sda_m = 1'b1; waitc(H);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; waitc(Q); scl_m = 1'b1; waitc(H); scl_m = 1'b0; waitc(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(H/2); b = sda_line;
    waitc(H/2); scl_m = 1'b0; waitc(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~ack);
  endtask

  function automatic logic [7:0] addr_byte(input logic [2:0] f, input logic rd);
    return {PREFIX, f, rd};
  endfunction

  function automatic int phys(input int page, input int ptr);
    return page * PSZ + (ptr % PSZ);
  endfunction

  // Start a write frame and load the pointer.
  task automatic set_ptr(input logic [2:0] f, input int ptr);
    logic ack;
    bus_start();
    put_byte(addr_byte(f, 1'b0), ack);
    chk("R2 address ack before pointer", int'(ack), 1);
    put_byte(8'(ptr), ack);
    chk("R4 pointer byte ack", int'(ack), 1);
  endtask

  initial begin
    logic ack;
    logic b;
    logic [7:0] d;
    int ptr;
    for (int i = 0; i < 8 * PSZ; i++) bm[i] = 8'h00;

    waitc(5);
    chk("R12 sda released in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    waitc(10);
    chk("R12 sda released after reset", int'(sda_oe), 0);

    // R12: fresh memory and pointer 0, read in memory mode page 7
    mem_mode = 1'b1;
    bus_start();
    put_byte(addr_byte(3'd7, 1'b1), ack);
    chk("R8 memory-mode read address ack", int'(ack), 1);
    get_byte(d, 1'b0);
    chk("R12 reset memory content", int'(d), 0);
    bus_stop();

    // R8: one byte pair per page at pointer 3
    for (int p = 0; p < 8; p++) begin
      set_ptr(3'(p), 3);
      put_byte(8'h40 + 8'(p), ack);
      chk("R5 page write ack", int'(ack), 1);
      put_byte(8'h80 + 8'(p), ack);
      chk("R5 page write ack", int'(ack), 1);
      bm[phys(p, 3)] = 8'h40 + 8'(p);
      bm[phys(p, 4)] = 8'h80 + 8'(p);
      bus_stop();
    end
    for (int p = 7; p >= 0; p--) begin
      set_ptr(3'(p), 3);
      bus_start();  // R1 repeated start
      put_byte(addr_byte(3'(p), 1'b1), ack);
      chk("R1 repeated start address ack", int'(ack), 1);
      get_byte(d, 1'b1);
      chk("R8 page readback", int'(d), int'(bm[phys(p, 3)]));
      get_byte(d, 1'b0);
      chk("R6 sequential read", int'(d), int'(bm[phys(p, 4)]));
      bus_stop();
    end
    // R8: pointer set through page 0, read through page 5
    set_ptr(3'd0, 3);
    bus_stop();
    bus_start();
    put_byte(addr_byte(3'd5, 1'b1), ack);
    get_byte(d, 1'b0);
    chk("R8 page from read address", int'(d), int'(bm[phys(5, 3)]));
    bus_stop();

    // Strap mode: 17 writes from pointer 0, last one wraps (R7)
    mem_mode = 1'b0;
    set_ptr(strap, 0);
    for (int i = 0; i < PSZ + 1; i++) begin
      put_byte(8'(i * 37 + 5), ack);
      chk("R5 strap write ack", int'(ack), 1);
      bm[phys(0, i)] = 8'(i * 37 + 5);
    end
    bus_stop();
    chk("R10 released after stop", int'(sda_oe), 0);

    // R7: read across the wrap point, then NACK (R9)
    set_ptr(strap, PSZ - 2);
    bus_start();
    put_byte(addr_byte(strap, 1'b1), ack);
    for (int i = 0; i < 4; i++) begin
      get_byte(d, i != 3);
      chk("R7 read wrap", int'(d), int'(bm[phys(0, PSZ - 2 + i)]));
    end
    get_bit(b);
    chk("R9 released after master NACK", int'(b), 1);
    bus_stop();
    chk("R10 idle after stop", int'(sda_oe), 0);

    // R2/R3: full address sweep in strap mode
    for (int a = 0; a < 128; a++) begin
      bus_start();
      put_byte({7'(a), 1'b0}, ack);
      chk("R2 address sweep ack", int'(ack),
          int'((a[6:3] == PREFIX) && (a[2:0] == strap)));
      if (!ack) begin
        put_byte(8'hFF, ack);
        chk("R3 data after mismatch not acked", int'(ack), 0);
      end
      bus_stop();
    end

    // R4: pointer kept across stop; whole page unchanged by the sweep
    set_ptr(strap, 0);
    bus_stop();
    bus_start();
    put_byte(addr_byte(strap, 1'b1), ack);
    for (int i = 0; i < PSZ; i++) begin
      get_byte(d, i != PSZ - 1);
      chk("R4 readback after stop", int'(d), int'(bm[phys(0, i)]));
    end
    bus_stop();

    // R1: repeated start during a write frame, then read back
    ptr = 9;
    set_ptr(strap, ptr);
    put_byte(8'h5C, ack);
    bm[phys(0, ptr)] = 8'h5C;
    set_ptr(strap, ptr);
    bus_start();
    put_byte(addr_byte(strap, 1'b1), ack);
    get_byte(d, 1'b0);
    chk("R1 read after repeated starts", int'(d), 32'h5C);
    bus_stop();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule